// File: doc/BRIEF.md
# Interrupt Enable and Acceptance Controller

This block keeps the interrupt-enable state of a small processor core and decides, cycle by cycle, whether the external interrupt request line is honoured. The request line is sampled only at the end of an instruction, or on any cycle while the core is halted. A request is refused when enable is off, and it is refused while the buses are handed over to another master.

When a request is honoured, the block sends a one-clock accept pulse to the cycle sequencer. If the core was halted, a halt-exit pulse goes out on the same cycle. The block also raises a flag so that the next instruction fetch becomes an acknowledge fetch. The sequencer marks the first state of that fetch with a strobe. On that strobe the enable state is cleared and the flag drops.

Reset clears every state bit in the block. Reset does not clear the processor's working registers. The external request passes through a configurable synchronizer before it is used.

Top module: `irq_enable_ctl`

## Requirements
- R1: While `rst` is sampled high at a rising edge, `ie_o`, `accept_o`, `ack_fetch_o` and `halt_exit_o` are all 0 after that edge. The synchronizer stages are cleared as well.
- R2: Control strobes take effect on the next clock. `en_strobe_i` sets `ie_o`. `dis_strobe_i` clears `ie_o`. When both are high on the same cycle, the disable wins.
- R3: No accept happens on a cycle where `ie_o` is 0.
- R4: A request is considered only on a cycle where `instr_end_i` is 1 or `halted_i` is 1.
- R5: No accept happens on a cycle where `hold_i` is 1.
- R6: An accept drives `accept_o` for exactly one clock, on the edge after the deciding cycle. `ack_fetch_o` rises on that same edge. No further accept occurs while `ack_fetch_o` is 1.
- R7: When `fetch_t1_i` is 1 while `ack_fetch_o` is 1, the next edge clears both `ack_fetch_o` and `ie_o`. This clear overrides an enable strobe on that cycle. When `ack_fetch_o` is 0, `fetch_t1_i` has no effect.
- R8: `halt_exit_o` pulses together with `accept_o` exactly when `halted_i` was 1 on the deciding cycle.
- R9: `irq_i` passes through `SYNC_STAGES` flip-flops (default 2) before the acceptance decision. A change on `irq_i` therefore affects a decision made `SYNC_STAGES` clocks later.
- R10: If the request stays high, re-setting enable after an acknowledge fetch lets the same request be accepted again at the next eligible cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 1 | External interrupt request level |
| en_strobe_i | input | 1 | Enable-interrupts instruction strobe |
| dis_strobe_i | input | 1 | Disable-interrupts instruction strobe |
| instr_end_i | input | 1 | Last cycle of the current instruction |
| halted_i | input | 1 | Core is in the halt state |
| hold_i | input | 1 | Buses are granted to another master |
| fetch_t1_i | input | 1 | First state of an instruction fetch |
| ie_o | output | 1 | Interrupt-enable state |
| accept_o | output | 1 | One-clock accept pulse to the sequencer |
| ack_fetch_o | output | 1 | The next fetch is an acknowledge fetch |
| halt_exit_o | output | 1 | Leave the halt state (pulses with an accept taken while halted) |

## Verification
A wrong enable state shows on `ie_o` one clock after the strobe or the fetch-state clear that caused it. A wrong decision shows as a missing or extra `accept_o` pulse one clock after the deciding cycle. A pending flag that sticks shows as `ack_fetch_o` staying high after a fetch strobe, which also suppresses later accepts. A synchronizer of the wrong depth shifts every accept by whole cycles, so a per-cycle comparison catches it at the first edge where the request changes.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  typedef struct packed {
    logic take;
    logic from_halt;
  } decision_t;

  typedef enum logic [1:0] {
    IE_HOLD_VAL = 2'd0,
    IE_SET      = 2'd1,
    IE_CLEAR    = 2'd2
  } ie_cmd_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d_i} & {STAGES{1'b1}};
      end
      assign q_o = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/ie_flop.sv
module ie_flop
  import irq_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic dis_i,
  input  logic auto_clr_i,
  output logic ie_o
);
  ie_cmd_t cmd;

  always_comb begin
    if (auto_clr_i || dis_i) cmd = IE_CLEAR;
    else if (en_i)           cmd = IE_SET;
    else                     cmd = IE_HOLD_VAL;
  end

  always_ff @(posedge clk) begin
    if (rst) ie_o <= 1'b0;
    else begin
      case (cmd)
        IE_SET:   ie_o <= 1'b1;
        IE_CLEAR: ie_o <= 1'b0;
        default:  ie_o <= ie_o;
      endcase
    end
  end

  // R2: disable beats enable on the same cycle
  a_r2_dis_wins: assert property (@(posedge clk) disable iff (rst)
    dis_i |=> !ie_o);
endmodule

// File: rtl/accept_gate.sv
module accept_gate
  import irq_ctl_pkg::*;
(
  input  logic      ie_i,
  input  logic      irq_i,
  input  logic      instr_end_i,
  input  logic      halted_i,
  input  logic      hold_i,
  input  logic      pending_i,
  output decision_t dec_o
);
  logic boundary;
  always_comb begin
    boundary        = instr_end_i || halted_i;
    dec_o.take      = ie_i && irq_i && boundary && !hold_i && !pending_i;
    dec_o.from_halt = dec_o.take && halted_i;
  end
endmodule

// File: rtl/irq_enable_ctl.sv
module irq_enable_ctl
  import irq_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic irq_i,
  input  logic en_strobe_i,
  input  logic dis_strobe_i,
  input  logic instr_end_i,
  input  logic halted_i,
  input  logic hold_i,
  input  logic fetch_t1_i,
  output logic ie_o,
  output logic accept_o,
  output logic ack_fetch_o,
  output logic halt_exit_o
);
  logic      irq_sync_q;
  logic      ack_start;
  decision_t dec;

  irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(irq_i), .q_o(irq_sync_q)
  );

  assign ack_start = fetch_t1_i && ack_fetch_o;

  ie_flop u_ie (
    .clk(clk), .rst(rst), .en_i(en_strobe_i), .dis_i(dis_strobe_i),
    .auto_clr_i(ack_start), .ie_o(ie_o)
  );

  accept_gate u_gate (
    .ie_i(ie_o), .irq_i(irq_sync_q), .instr_end_i(instr_end_i),
    .halted_i(halted_i), .hold_i(hold_i), .pending_i(ack_fetch_o),
    .dec_o(dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      accept_o    <= 1'b0;
      halt_exit_o <= 1'b0;
      ack_fetch_o <= 1'b0;
    end else begin
      accept_o    <= dec.take;
      halt_exit_o <= dec.from_halt;
      if (dec.take)       ack_fetch_o <= 1'b1;
      else if (ack_start) ack_fetch_o <= 1'b0;
    end
  end

  // R6: pulse is a single clock wide
  a_r6_one_clock: assert property (@(posedge clk) disable iff (rst)
    accept_o |=> !accept_o);
  // R6: pending flag accompanies the pulse
  a_r6_flag_with_pulse: assert property (@(posedge clk) disable iff (rst)
    accept_o |-> ack_fetch_o);
  // R3: enable must have been set on the deciding cycle
  a_r3_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(accept_o) |-> $past(ie_o));
  // R5: hold blocks acceptance
  a_r5_hold_blocks: assert property (@(posedge clk) disable iff (rst)
    $rose(accept_o) |-> !$past(hold_i));
  // R7: fetch-state strobe clears enable and the pending flag
  a_r7_t1_clears: assert property (@(posedge clk) disable iff (rst)
    (fetch_t1_i && ack_fetch_o) |=> (!ie_o && !ack_fetch_o));
  // R8: halt exit only alongside an accept
  a_r8_exit_with_accept: assert property (@(posedge clk) disable iff (rst)
    halt_exit_o |-> accept_o);
endmodule

// File: tb/test_irq_enable_ctl.sv
module test_irq_enable_ctl;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst, irq, en_s, dis_s, iend, halted, hold, t1;
  logic ie, acc, ackf, hexit;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  irq_enable_ctl #(.SYNC_STAGES(SYNC)) i_irq_enable_ctl (
    .clk(clk), .rst(rst), .irq_i(irq), .en_strobe_i(en_s), .dis_strobe_i(dis_s),
    .instr_end_i(iend), .halted_i(halted), .hold_i(hold), .fetch_t1_i(t1),
    .ie_o(ie), .accept_o(acc), .ack_fetch_o(ackf), .halt_exit_o(hexit)
  );

  // Reference model written from the requirements
  logic [SYNC-1:0] m_sync;
  logic m_ie, m_acc, m_pend, m_hx, m_take;
  always_comb m_take = m_ie && m_sync[SYNC-1] && (iend || halted) && !hold && !m_pend;
  always @(posedge clk) begin
    if (rst) begin
      m_sync <= '0; m_ie <= 0; m_acc <= 0; m_pend <= 0; m_hx <= 0;
    end else begin
      m_sync <= {m_sync[SYNC-2:0], irq};
      m_acc  <= m_take;
      m_hx   <= m_take && halted;
      m_pend <= m_take ? 1'b1 : ((t1 && m_pend) ? 1'b0 : m_pend);
      m_ie   <= (t1 && m_pend) ? 1'b0 : (dis_s ? 1'b0 : (en_s ? 1'b1 : m_ie));
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk(ie,    m_ie,   "R2 R7 ie_o");
    chk(acc,   m_acc,  "R3 R4 R5 R6 R9 accept_o");
    chk(ackf,  m_pend, "R6 R7 ack_fetch_o");
    chk(hexit, m_hx,   "R8 halt_exit_o");
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); cmp_all();
  endtask

  task automatic idle();
    en_s = 0; dis_s = 0; iend = 0; t1 = 0;
  endtask

  initial begin : watchdog
    #1500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    rst = 1; irq = 0; halted = 0; hold = 0; idle();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ie, 1'b0, "R1 ie"); chk(acc, 1'b0, "R1 accept");
    chk(ackf, 1'b0, "R1 ackf"); chk(hexit, 1'b0, "R1 hexit");
    rst = 0;
    step();
    // R3: request with enable off is refused
    irq = 1; repeat (SYNC + 1) step();
    iend = 1; step(); iend = 0; step();
    chk(acc, 1'b0, "R3 disabled");
    // R2: enable and disable together, disable wins
    en_s = 1; dis_s = 1; step(); idle();
    chk(ie, 1'b0, "R2 both");
    en_s = 1; step(); idle();
    chk(ie, 1'b1, "R2 set");
    // R4: no boundary, no accept
    repeat (3) step();
    chk(acc, 1'b0, "R4 mid-instruction");
    // R5: hold blocks
    hold = 1; iend = 1; step(); iend = 0; hold = 0;
    chk(acc, 1'b0, "R5 hold");
    // R6: accept at boundary
    iend = 1; step(); iend = 0;
    chk(acc, 1'b1, "R6 pulse"); chk(ackf, 1'b1, "R6 flag");
    iend = 1; step(); iend = 0;
    chk(acc, 1'b0, "R6 no repeat");
    // R7: fetch strobe clears enable and flag
    en_s = 1; t1 = 1; step(); idle();
    chk(ie, 1'b0, "R7 ie clear"); chk(ackf, 1'b0, "R7 flag clear");
    // R10: re-enable with request still high, accept while halted (R8)
    en_s = 1; step(); idle();
    halted = 1; step(); halted = 0;
    chk(acc, 1'b1, "R10 reaccept"); chk(hexit, 1'b1, "R8 halt exit");
    t1 = 1; step(); idle();
    // R9: request drop takes SYNC clocks to reach the decision
    en_s = 1; step(); idle();
    irq = 0; iend = 1; step();
    chk(acc, 1'b1, "R9 stale request still seen");
    t1 = 1; iend = 0; step(); t1 = 0;
    en_s = 1; step(); idle();
    iend = 1; step(); iend = 0;
    chk(acc, 1'b0, "R9 dropped request");
    // Sweep with pseudo-random stimulus
    lfsr = 16'hACE1;
    for (int i = 0; i < 6000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rst    = (lfsr[5:0] == 6'd0);
      en_s   = (lfsr[2:0] == 3'd3);
      dis_s  = (lfsr[6:4] == 3'd5);
      iend   = lfsr[8] & lfsr[9];
      if (lfsr[11:10] == 2'd0) halted = ~halted;
      hold   = (lfsr[14:12] == 3'd7);
      t1     = lfsr[1] & lfsr[7];
      if (lfsr[15] & lfsr[3]) irq = ~irq;
      step();
    end
    rst = 0; idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule